// File: doc/BRIEF.md
# Packetizing Multi-Buffer IN FIFO

This block collects a continuous byte stream from an external writer and hands it to a consumer as whole packets. Storage is a ring of `NUM_BUFS` equal buffers, each `PKT_BYTES` long (four buffers by default; two or three also work). The writer presents one byte per cycle with `wr_en`. The buffer being filled is closed ("committed") in one of two ways: it fills up, or the writer pulses `wr_pkt_end` to send a short packet. The next byte then goes into the following free buffer with no further action from the writer.

The consumer sees `rd_pkt_valid` whenever at least one packet is committed. It reads the oldest packet's byte count on `rd_len` and its bytes by offset through `rd_addr`/`rd_data`. It then pulses `rd_release` to return that buffer to the writer. The writer can fill a buffer while the consumer still holds any of the others. The status outputs count committed buffers, not bytes. A programmable level flag compares that count against `level_thresh`. Both sides share one clock. The reset input is asserted asynchronously and its release is synchronized inside the block.

Top module: `pkt_ring_fifo`

## Requirements
- R1: Packets are delivered in the order they were committed, with buffers used in round-robin order. Byte k of a packet (counting from 0 in write order) is returned on `rd_data` while `rd_addr` equals k.
- R2: An accepted byte that brings the current buffer to `PKT_BYTES` bytes commits it with `rd_len` = `PKT_BYTES`. The next accepted byte starts a new buffer at offset 0.
- R3: A `wr_pkt_end` pulse commits the current buffer with its actual byte count, including a byte accepted in the same cycle. A pulse on a buffer holding no bytes commits a zero-length packet.
- R4: Bytes are accepted into a free buffer while committed packets remain unread, including in the same cycle as a release.
- R5: `rd_pkt_valid` is 1 exactly when at least one packet is committed. `rd_len` stays stable until the oldest packet is released. A `rd_release` while `rd_pkt_valid` is 0 has no effect.
- R6: `full` is 1 exactly when all `NUM_BUFS` buffers are committed and unreleased.
- R7: `empty` is 1 exactly when no buffer is committed and the current buffer holds no bytes.
- R8: `level_flag` is 1 exactly when `level_thresh` is nonzero and the number of committed buffers is at least `level_thresh`.
- R9: While `full` is 1, `wr_en` stores nothing and `wr_pkt_end` commits nothing. A rejected write makes `overflow` 1 for the following cycle only.
- R10: After reset, `empty`=1 and `full`, `level_flag`, `rd_pkt_valid` and `overflow` are 0. No partial bytes survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | DATA_W | Byte to write |
| wr_pkt_end | input | 1 | Commit the current buffer as a short packet |
| level_thresh | input | CNT_W | Committed-buffer threshold for `level_flag` (0 disables) |
| rd_pkt_valid | output | 1 | At least one committed packet is waiting |
| rd_len | output | LEN_W | Byte count of the oldest committed packet |
| rd_addr | input | IDX_W | Byte offset within the oldest packet |
| rd_data | output | DATA_W | Byte at `rd_addr` of the oldest packet |
| rd_release | input | 1 | Free the oldest packet's buffer |
| full | output | 1 | Every buffer is committed |
| empty | output | 1 | No committed buffer and no partial bytes |
| level_flag | output | 1 | Committed count has reached `level_thresh` |
| overflow | output | 1 | One-cycle pulse after a rejected write |

## Verification
The hardest case to reach from the ports is a full ring. There, a write, a packet-end pulse and a release can meet in one cycle, and the write must be rejected even though the release frees a buffer in that same cycle. The stimulus reaches this by committing packets back to back without reading until `full` rises. It then drives rejected writes with a marker byte, a packet-end pulse, and a combined write and release. Draining the ring afterwards must show that no marker byte was stored and no extra packet was created. Sweeping every short length in both packet-end timings, together with reads and writes in the same cycle, carries both pointers around the ring several times.

// File: rtl/pkt_ring_pkg.sv
package pkt_ring_pkg;

  // Reason a buffer was closed in the current cycle.
  typedef enum logic [1:0] {
    COMMIT_NONE   = 2'd0,
    COMMIT_FILLED = 2'd1,
    COMMIT_SHORT  = 2'd2
  } commit_e;

endpackage

// File: rtl/pkt_ring_rst_sync.sv
module pkt_ring_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pkt_ring_store.sv
module pkt_ring_store #(
  parameter int DATA_W    = 8,
  parameter int PKT_BYTES = 16,
  parameter int NUM_BUFS  = 4,
  parameter int LEN_W     = 5,
  parameter int IDX_W     = 4,
  parameter int PTR_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  // byte write port
  input  logic              byte_we,
  input  logic [PTR_W-1:0]  byte_buf,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [DATA_W-1:0] byte_data,
  // length write port (on commit)
  input  logic              len_we,
  input  logic [PTR_W-1:0]  len_buf,
  input  logic [LEN_W-1:0]  len_val,
  // read port
  input  logic [PTR_W-1:0]  rd_buf,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [LEN_W-1:0]  rd_len
);

  logic [DATA_W-1:0] buf_rd_data [NUM_BUFS];
  logic [LEN_W-1:0]  buf_len     [NUM_BUFS];

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
    logic [DATA_W-1:0] mem_q [PKT_BYTES];
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  len_nxt;
    logic              mem_en;
    logic              len_en;

    always_comb begin
      mem_en  = byte_we && (byte_buf == PTR_W'(b));
      len_en  = len_we && (len_buf == PTR_W'(b));
      len_nxt = len_val;
    end

    // Data storage carries no reset; only written bytes are ever read.
    always_ff @(posedge clk) begin
      if (mem_en) begin
        mem_q[byte_idx] <= byte_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q <= '0;
      end else if (len_en) begin
        len_q <= len_nxt;
      end
    end

    assign buf_rd_data[b] = mem_q[rd_idx];
    assign buf_len[b]     = len_q;
  end

  assign rd_data = buf_rd_data[rd_buf];
  assign rd_len  = buf_len[rd_buf];

endmodule

// File: rtl/pkt_ring_wr_ctl.sv
module pkt_ring_wr_ctl
  import pkt_ring_pkg::*;
#(
  parameter int PKT_BYTES = 16,
  parameter int NUM_BUFS  = 4,
  parameter int LEN_W     = 5,
  parameter int PTR_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_pkt_end,
  input  logic             ring_full,
  output logic             byte_accept,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [LEN_W-1:0] fill_cnt,
  output commit_e          commit_kind,
  output logic [LEN_W-1:0] commit_len,
  output logic             overflow
);

  logic [PTR_W-1:0] ptr_q, ptr_nxt;
  logic [LEN_W-1:0] fill_q, fill_nxt;
  logic             ovf_q, ovf_nxt;
  logic             ptr_en, fill_en;
  logic             last_byte;
  logic             fills_buf;
  logic             short_end;

  always_comb begin
    byte_accept = wr_en && !ring_full;
    last_byte   = (fill_q == LEN_W'(PKT_BYTES - 1));
    fills_buf   = byte_accept && last_byte;
    short_end   = wr_pkt_end && !ring_full && !fills_buf;

    if (fills_buf) begin
      commit_kind = COMMIT_FILLED;
    end else if (short_end) begin
      commit_kind = COMMIT_SHORT;
    end else begin
      commit_kind = COMMIT_NONE;
    end

    commit_len = fill_q + LEN_W'(byte_accept);

    ptr_en  = (commit_kind != COMMIT_NONE);
    ptr_nxt = (ptr_q == PTR_W'(NUM_BUFS - 1)) ? '0 : ptr_q + PTR_W'(1);

    fill_en  = byte_accept || short_end;
    fill_nxt = ptr_en ? '0 : fill_q + LEN_W'(byte_accept);

    ovf_nxt = wr_en && ring_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (fill_en) begin
      fill_q <= fill_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_nxt;
    end
  end

  assign wr_ptr   = ptr_q;
  assign fill_cnt = fill_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/pkt_ring_rd_ctl.sv
module pkt_ring_rd_ctl #(
  parameter int NUM_BUFS = 4,
  parameter int PTR_W    = 2,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_valid,
  input  logic             wr_fill_zero,
  input  logic             rd_release,
  input  logic [CNT_W-1:0] level_thresh,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] used_cnt,
  output logic             pkt_valid,
  output logic             full,
  output logic             empty,
  output logic             level_flag
);

  logic [PTR_W-1:0] ptr_q, ptr_nxt;
  logic [CNT_W-1:0] used_q, used_nxt;
  logic             rel_ok;
  logic             used_en;

  always_comb begin
    rel_ok   = rd_release && (used_q != '0);
    used_en  = commit_valid ^ rel_ok;
    used_nxt = used_q + CNT_W'(commit_valid) - CNT_W'(rel_ok);
    ptr_nxt  = (ptr_q == PTR_W'(NUM_BUFS - 1)) ? '0 : ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (rel_ok) begin
      ptr_q <= ptr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (used_en) begin
      used_q <= used_nxt;
    end
  end

  always_comb begin
    pkt_valid  = (used_q != '0);
    full       = (used_q == CNT_W'(NUM_BUFS));
    empty      = (used_q == '0) && wr_fill_zero;
    level_flag = (level_thresh != '0) && (used_q >= level_thresh);
  end

  assign rd_ptr   = ptr_q;
  assign used_cnt = used_q;

endmodule

// File: rtl/pkt_ring_fifo.sv
module pkt_ring_fifo
  import pkt_ring_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PKT_BYTES = 16,
  parameter int NUM_BUFS  = 4,
  localparam int LEN_W    = $clog2(PKT_BYTES + 1),
  localparam int IDX_W    = (PKT_BYTES > 1) ? $clog2(PKT_BYTES) : 1,
  localparam int PTR_W    = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int CNT_W    = $clog2(NUM_BUFS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_pkt_end,
  input  logic [CNT_W-1:0]  level_thresh,
  output logic              rd_pkt_valid,
  output logic [LEN_W-1:0]  rd_len,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_release,
  output logic              full,
  output logic              empty,
  output logic              level_flag,
  output logic              overflow
);

  logic             rst_sync_n;
  logic             byte_accept;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [LEN_W-1:0] fill_cnt;
  logic [LEN_W-1:0] commit_len;
  logic [CNT_W-1:0] used_cnt;
  commit_e          commit_kind;
  logic             commit_valid;

  pkt_ring_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pkt_ring_wr_ctl #(
    .PKT_BYTES (PKT_BYTES),
    .NUM_BUFS  (NUM_BUFS),
    .LEN_W     (LEN_W),
    .PTR_W     (PTR_W)
  ) u_wr_ctl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (wr_en),
    .wr_pkt_end  (wr_pkt_end),
    .ring_full   (full),
    .byte_accept (byte_accept),
    .wr_ptr      (wr_ptr),
    .fill_cnt    (fill_cnt),
    .commit_kind (commit_kind),
    .commit_len  (commit_len),
    .overflow    (overflow)
  );

  assign commit_valid = (commit_kind != COMMIT_NONE);

  pkt_ring_rd_ctl #(
    .NUM_BUFS (NUM_BUFS),
    .PTR_W    (PTR_W),
    .CNT_W    (CNT_W)
  ) u_rd_ctl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .commit_valid (commit_valid),
    .wr_fill_zero (fill_cnt == '0),
    .rd_release   (rd_release),
    .level_thresh (level_thresh),
    .rd_ptr       (rd_ptr),
    .used_cnt     (used_cnt),
    .pkt_valid    (rd_pkt_valid),
    .full         (full),
    .empty        (empty),
    .level_flag   (level_flag)
  );

  pkt_ring_store #(
    .DATA_W    (DATA_W),
    .PKT_BYTES (PKT_BYTES),
    .NUM_BUFS  (NUM_BUFS),
    .LEN_W     (LEN_W),
    .IDX_W     (IDX_W),
    .PTR_W     (PTR_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .byte_we   (byte_accept),
    .byte_buf  (wr_ptr),
    .byte_idx  (IDX_W'(fill_cnt)),
    .byte_data (wr_data),
    .len_we    (commit_valid),
    .len_buf   (wr_ptr),
    .len_val   (commit_len),
    .rd_buf    (rd_ptr),
    .rd_idx    (rd_addr),
    .rd_data   (rd_data),
    .rd_len    (rd_len)
  );

endmodule

// File: rtl/pkt_ring_chk.sv
module pkt_ring_chk #(
  parameter int PKT_BYTES = 16,
  parameter int NUM_BUFS  = 4,
  parameter int LEN_W     = 5,
  parameter int CNT_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_pkt_end,
  input logic             rd_release,
  input logic [CNT_W-1:0] level_thresh,
  input logic             rd_pkt_valid,
  input logic [LEN_W-1:0] rd_len,
  input logic             full,
  input logic             empty,
  input logic             level_flag,
  input logic             overflow,
  input logic [LEN_W-1:0] fill_cnt,
  input logic [CNT_W-1:0] used_cnt
);

  // R2: the byte that completes a buffer leaves the next buffer at offset 0
  a_r2_autocommit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && fill_cnt == LEN_W'(PKT_BYTES - 1)) |=> (fill_cnt == '0));

  // R5: the oldest packet's length holds until it is released
  a_r5_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pkt_valid && !rd_release) |=> (rd_pkt_valid && $stable(rd_len)));

  // R5: a release without a write side commit lowers the count by one
  a_r5_release_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pkt_valid && rd_release && !wr_en && !wr_pkt_end)
      |=> (used_cnt == $past(used_cnt) - CNT_W'(1)));

  // R6: a full ring always offers a packet and is never empty
  a_r6_full_has_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (rd_pkt_valid && !empty));

  // R7: an empty ring offers no packet
  a_r7_empty_no_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!rd_pkt_valid && !full));

  // R8: a zero threshold keeps the level flag low
  a_r8_level_off: assert property (@(posedge clk) disable iff (!rst_n)
    (level_thresh == '0) |-> !level_flag);

  // R8: any threshold within range is reached when the ring is full
  a_r8_level_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && level_thresh != '0 && level_thresh <= CNT_W'(NUM_BUFS)) |-> level_flag);

  // R9: a rejected write raises overflow on the next cycle
  a_r9_overflow_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> overflow);

  // R9: overflow lasts only one cycle per rejected write
  a_r9_overflow_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && full) |=> !overflow);

  // R9: rejected input cannot take the ring out of full
  a_r9_stay_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_release) |=> full);

endmodule

bind pkt_ring_fifo pkt_ring_chk #(
  .PKT_BYTES (PKT_BYTES),
  .NUM_BUFS  (NUM_BUFS),
  .LEN_W     (LEN_W),
  .CNT_W     (CNT_W)
) u_pkt_ring_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .wr_en        (wr_en),
  .wr_pkt_end   (wr_pkt_end),
  .rd_release   (rd_release),
  .level_thresh (level_thresh),
  .rd_pkt_valid (rd_pkt_valid),
  .rd_len       (rd_len),
  .full         (full),
  .empty        (empty),
  .level_flag   (level_flag),
  .overflow     (overflow),
  .fill_cnt     (fill_cnt),
  .used_cnt     (used_cnt)
);

// File: tb/test_pkt_ring_fifo.sv
module test_pkt_ring_fifo;

  localparam int DW = 8;
  localparam int PB = 4;
  localparam int NB = 4;
  localparam int LW = $clog2(PB + 1);
  localparam int IW = $clog2(PB);
  localparam int CW = $clog2(NB + 1);

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic          wr_pkt_end;
  logic [CW-1:0] level_thresh;
  logic          rd_pkt_valid;
  logic [LW-1:0] rd_len;
  logic [IW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          rd_release;
  logic          full;
  logic          empty;
  logic          level_flag;
  logic          overflow;

  pkt_ring_fifo #(
    .DATA_W    (DW),
    .PKT_BYTES (PB),
    .NUM_BUFS  (NB)
  ) i_pkt_ring_fifo (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .wr_pkt_end   (wr_pkt_end),
    .level_thresh (level_thresh),
    .rd_pkt_valid (rd_pkt_valid),
    .rd_len       (rd_len),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .rd_release   (rd_release),
    .full         (full),
    .empty        (empty),
    .level_flag   (level_flag),
    .overflow     (overflow)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks;
  int fails;
  bit done;

  // reference state, derived from the requirements
  logic [7:0] exp_data [NB][PB];
  int exp_len [NB];
  int m_wp, m_rp, m_cnt, m_fill, m_th, seq;
  bit m_ovf;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(input int s);
    return 8'((s * 29 + 3) & 255);
  endfunction

  task automatic model_reset();
    m_wp = 0; m_rp = 0; m_cnt = 0; m_fill = 0; m_ovf = 0;
  endtask

  task automatic check_flags();
    chk("R6 full", int'(full), int'(m_cnt == NB));
    chk("R7 empty", int'(empty), int'(m_cnt == 0 && m_fill == 0));
    chk("R5 rd_pkt_valid", int'(rd_pkt_valid), int'(m_cnt > 0));
    chk("R8 level_flag", int'(level_flag), int'(m_th != 0 && m_cnt >= m_th));
    chk("R9 overflow", int'(overflow), int'(m_ovf));
    if (m_cnt > 0) chk("R3 rd_len", int'(rd_len), exp_len[m_rp]);
  endtask

  task automatic step(input bit we, input logic [7:0] d, input bit pe, input bit rel);
    bit full_old;
    bit commit;
    full_old = (m_cnt == NB);
    m_th = (m_th + 1) % (NB + 1);
    wr_en = we; wr_data = d; wr_pkt_end = pe; rd_release = rel;
    level_thresh = CW'(m_th);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_pkt_end = 1'b0; rd_release = 1'b0;
    commit = 1'b0;
    if (we && !full_old) begin
      exp_data[m_wp][m_fill] = d;
      m_fill++;
      if (m_fill == PB) commit = 1'b1;
    end
    if (pe && !full_old) commit = 1'b1;
    if (rel && m_cnt > 0) begin
      m_rp = (m_rp + 1) % NB;
      m_cnt--;
    end
    if (commit) begin
      exp_len[m_wp] = m_fill;
      m_wp = (m_wp + 1) % NB;
      m_cnt++;
      m_fill = 0;
    end
    m_ovf = we && full_old;
    check_flags();
  endtask

  // Check every byte of the oldest packet, then release it (optionally writing too).
  task automatic read_pkt(input string tag, input bit also_write, input logic [7:0] d);
    chk({tag, " packet present"}, int'(rd_pkt_valid), 1);
    for (int i = 0; i < exp_len[m_rp]; i++) begin
      rd_addr = IW'(i);
      #1;
      chk({tag, " data"}, int'(rd_data), int'(exp_data[m_rp][i]));
    end
    step(also_write, d, 1'b0, 1'b1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    model_reset();
    chk("R10 empty after reset", int'(empty), 1);
    chk("R10 full after reset", int'(full), 0);
    chk("R10 level_flag after reset", int'(level_flag), 0);
    chk("R10 rd_pkt_valid after reset", int'(rd_pkt_valid), 0);
    chk("R10 overflow after reset", int'(overflow), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0; seq = 0; m_th = 1;
    wr_en = 0; wr_data = '0; wr_pkt_end = 0; rd_release = 0; rd_addr = '0;
    level_thresh = CW'(1);
    @(negedge clk);
    do_reset();

    // Every short and full length, packet-end with or after the last byte.
    for (int mode = 0; mode < 2; mode++) begin
      for (int len = 0; len <= PB; len++) begin
        for (int i = 0; i < len; i++) begin
          step(1'b1, dat(seq), (mode == 0 && i == len - 1), 1'b0);
          seq++;
        end
        if (len == PB && mode == 1)
          chk("R2 autocommit on last byte", int'(rd_pkt_valid), 1);
        if (mode == 1 || len == 0) step(1'b0, 8'h00, 1'b1, 1'b0);
        if (len == PB) chk("R2 full length", int'(rd_len), PB);
        else chk("R3 short length", int'(rd_len), len);
        while (m_cnt > 0) read_pkt("R1", 1'b0, 8'h00);
      end
    end

    // Fill the ring, then push rejected input at it.
    for (int p = 0; p < NB; p++) begin
      for (int i = 0; i < PB; i++) begin
        step(1'b1, dat(seq), 1'b0, 1'b0);
        seq++;
      end
    end
    chk("R6 full after all buffers committed", int'(full), 1);
    step(1'b1, 8'hEE, 1'b0, 1'b0);
    step(1'b1, 8'hEE, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R9 no packet from end strobe while full", int'(full), 1);
    read_pkt("R9", 1'b1, 8'hEE);
    chk("R9 write with release while full rejected", int'(empty), 0);
    while (m_cnt > 0) read_pkt("R9", 1'b0, 8'h00);
    chk("R9 nothing stored while full", int'(empty), 1);

    // Release with nothing committed.
    step(1'b0, 8'h00, 1'b0, 1'b1);
    chk("R5 release on empty ignored", int'(empty), 1);

    // Writer keeps filling while reader drains, same-cycle write and release.
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < PB; i++) begin
        step(1'b1, dat(seq), 1'b0, 1'b0);
        seq++;
      end
    end
    for (int k = 0; k < 2; k++) begin
      read_pkt("R4", 1'b1, dat(seq));
      seq++;
    end
    chk("R4 bytes accepted during drain", int'(rd_pkt_valid), 0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R4 concurrent packet length", int'(rd_len), 2);
    read_pkt("R4", 1'b0, 8'h00);

    // Reset in the middle of a partial packet.
    step(1'b1, dat(seq), 1'b1, 1'b0); seq++;
    step(1'b1, dat(seq), 1'b0, 1'b0); seq++;
    do_reset();
    step(1'b1, dat(seq), 1'b1, 1'b0); seq++;
    chk("R10 partial bytes cleared", int'(rd_len), 1);
    read_pkt("R10", 1'b0, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule